// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that executes a chain of transfer descriptors kept in system memory. Software places 32-byte descriptors in memory, writes the address of the first one into the channel's descriptor pointer, sets the enable bit and writes the doorbell. The channel reads the eight words of the descriptor over a word-wide memory master port. If the descriptor is marked valid, the channel copies the requested bytes from source to destination, one word at a time, with both addresses incrementing. Afterwards it optionally records a completion word, optionally marks the descriptor as consumed, and moves on to the next descriptor in the chain.

The chain ends at the first descriptor whose valid flag is clear. Every completed descriptor sets a sticky pending flag. A per-descriptor enable bit decides whether that flag also drives the interrupt pin. Clearing the channel enable stops the copy cleanly at a word boundary. The remaining byte count can then be read back.

Top module: `dbch_top`

## Requirements
- R1: After reset the status register (index 5) reads 1: halted is bit 0, descriptor-valid is bit 1, doorbell is bit 2. The pending register (index 4), the byte-count register (index 6) and the `irq` pin read 0, and `mem_req` is low.
- R2: A write of any value to the doorbell register (index 3) starts the channel only when bit 0 of the config register (index 0) is 1. Otherwise the write causes no memory request and the channel stays halted. While running, status bit 2 reads 1 and bit 0 reads 0.
- R3: The channel reads the descriptor as eight consecutive words starting at the descriptor pointer (index 1) with its low 5 bits forced to zero. The words are, in order: control, extension/count, source, unused, destination, unused, completion word, link.
- R4: A descriptor whose control word has bit 31 clear stops the chain with no data transfer. Status then reads 1: halted set, valid clear, doorbell clear.
- R5: A valid descriptor copies ceil(N/4) words, where N is bits 21:0 of the extension/count word. Word k is read from S+4k and written to D+4k. S is the source word with bits 31:28 taken from extension bits 31:28. D is the destination word with bits 31:28 taken from extension bits 27:24. Words beyond the count are left untouched.
- R6: After a descriptor completes, the channel fetches the next descriptor from link bits 26:0 shifted left by 5. When the chain stops, the descriptor pointer register shows the address of the descriptor it stopped on.
- R7: Bits 1:0 of the control word select the completion write. 0 writes nothing. 1 writes the status register value (6 while running). 2 writes the control word with bit 31 cleared. 3 writes the remaining byte count. The write goes to the descriptor's completion word (offset 24), or to the completion-pointer register (index 2) when control bit 4 is 1.
- R8: When control bit 2 is 1, the control word with bit 31 cleared is written back to the descriptor's first word after completion. When control bit 2 is 0, that word is left unchanged.
- R9: Each completed descriptor sets pending bit 0 (index 4), whatever its control bit 8. The `irq` pin is high only while pending is set and the last completed descriptor had control bit 8 set. Writing 1 to pending bit 0 clears it.
- R10: Clearing config bit 0 during a copy lets at most the word in flight complete. The channel then halts with status 3 (halted, valid), and the byte count shows the bytes not yet copied.
- R11: The byte-count register holds N when the copy starts and drops by 4 per copied word, with a floor of 0. It reads 0 after a descriptor completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts request; read data valid in the same cycle |
| mem_rdata | input | 32 | Memory read data |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the channel with its default parameters: 32-bit words and an eight-word descriptor, which gives a 27-bit link field. A 1 KB memory model is enough to hold the descriptors, the buffers and the completion word. Because the descriptor is small, the bench can sweep byte counts 0 to 9, which covers every round-up remainder and the zero-length case. It also runs all eight combinations of completion action and target, both settings of the consume bit, and three memory-ready patterns, and predicts every buffer word arithmetically.

// File: rtl/dbch_pkg.sv
package dbch_pkg;
    localparam int DW      = 32;
    localparam int WORDS   = 8;
    localparam int IW      = $clog2(WORDS);
    localparam int ALIGN   = $clog2(WORDS * (DW / 8));
    localparam int LINK_W  = DW - ALIGN;
    localparam int BCW     = 22;
    localparam int REG_AW  = 3;
    localparam int NREG    = 7;

    // register indices
    localparam int RA_CFG  = 0;
    localparam int RA_DPTR = 1;
    localparam int RA_SPTR = 2;
    localparam int RA_BELL = 3;
    localparam int RA_PEND = 4;
    localparam int RA_STAT = 5;
    localparam int RA_BCNT = 6;

    // descriptor word slots
    localparam int W_CTRL  = 0;
    localparam int W_EXT   = 1;
    localparam int W_SRC   = 2;
    localparam int W_DST   = 4;
    localparam int W_DONE  = 6;
    localparam int W_LINK  = 7;

    // control word bit positions
    localparam int C_VALID = 31;
    localparam int C_IE    = 8;
    localparam int C_SPSEL = 4;
    localparam int C_CONS  = 2;

    typedef enum logic [3:0] {
        S_IDLE, S_FETCH, S_CHECK, S_RD, S_WR, S_FIN, S_STWB, S_CLRV, S_NEXT
    } eng_st_e;

    typedef struct packed {
        eng_st_e         st;
        logic [IW-1:0]   widx;
        logic [DW-1:0]   src;
        logic [DW-1:0]   dst;
        logic [BCW-1:0]  bytes;
        logic [DW-1:0]   data;
        logic            halted;
        logic            valid;
        logic            bell;
        logic [DW-1:0]   dptr;
    } eng_t;

    typedef struct packed {
        logic          en;
        logic [DW-1:0] sptr;
        logic          pend;
        logic          ie;
    } rf_t;
endpackage

// File: rtl/dbch_desc_store.sv
module dbch_desc_store #(
    parameter int DW    = 32,
    parameter int WORDS = 8,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_en,
    input  logic [IW-1:0]       cap_idx,
    input  logic [DW-1:0]       cap_data,
    output logic [WORDS*DW-1:0] words
);
    for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
        logic [DW-1:0] w_d, w_q;
        always_comb begin
            w_d = w_q;
            if (cap_en && cap_idx == IW'(gi)) w_d = cap_data;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) w_q <= '0;
            else        w_q <= w_d;
        end
        assign words[gi*DW +: DW] = w_q;
    end
endmodule

// File: rtl/dbch_regs.sv
module dbch_regs
    import dbch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              cfg_en,
    output logic [DW-1:0]     sptr,
    output logic              bell,
    output logic              dptr_we,
    output logic [DW-1:0]     dptr_wdata,
    input  logic              done,
    input  logic              done_ie,
    input  logic [DW-1:0]     dptr,
    input  logic [2:0]        stat_bits,
    input  logic [BCW-1:0]    bytes,
    output logic              irq
);
    rf_t q, n;
    logic [NREG-1:0] sel;
    logic            pend_clr;

    for (genvar gi = 0; gi < NREG; gi++) begin : g_sel
        assign sel[gi] = reg_we && (reg_addr == REG_AW'(gi));
    end

    assign pend_clr = sel[RA_PEND] && reg_wdata[0];

    always_comb begin
        n = q;
        if (sel[RA_CFG])  n.en   = reg_wdata[0];
        if (sel[RA_SPTR]) n.sptr = reg_wdata;
        if (pend_clr)     n.pend = 1'b0;
        if (done) begin
            n.pend = 1'b1;
            n.ie   = done_ie;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_AW'(RA_CFG):  reg_rdata = {{(DW-1){1'b0}}, q.en};
            REG_AW'(RA_DPTR): reg_rdata = dptr;
            REG_AW'(RA_SPTR): reg_rdata = q.sptr;
            REG_AW'(RA_PEND): reg_rdata = {{(DW-1){1'b0}}, q.pend};
            REG_AW'(RA_STAT): reg_rdata = {{(DW-3){1'b0}}, stat_bits};
            REG_AW'(RA_BCNT): reg_rdata = {{(DW-BCW){1'b0}}, bytes};
            default:          reg_rdata = '0;
        endcase
    end

    assign cfg_en     = q.en;
    assign sptr       = q.sptr;
    assign bell       = sel[RA_BELL];
    assign dptr_we    = sel[RA_DPTR];
    assign dptr_wdata = reg_wdata;
    assign irq        = q.pend & q.ie;

    p_pend_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q.pend && !pend_clr |=> q.pend);
    p_done_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> q.pend);
endmodule

// File: rtl/dbch_engine.sv
module dbch_engine
    import dbch_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_en,
    input  logic                bell,
    input  logic                dptr_we,
    input  logic [DW-1:0]       dptr_wdata,
    input  logic [DW-1:0]       sptr,
    output logic                mem_req,
    output logic                mem_we,
    output logic [DW-1:0]       mem_addr,
    output logic [DW-1:0]       mem_wdata,
    input  logic                mem_ready,
    input  logic [DW-1:0]       mem_rdata,
    output logic                cap_en,
    output logic [IW-1:0]       cap_idx,
    input  logic [WORDS*DW-1:0] desc_words,
    output logic                done,
    output logic                done_ie,
    output logic [DW-1:0]       dptr,
    output logic [2:0]          stat_bits,
    output logic [BCW-1:0]      bytes
);
    localparam int STEP = DW / 8;

    eng_t q, n;
    logic [DW-1:0] ctrl, ext, src0, dst0, link;
    logic          xfer;
    logic [DW-1:0] ctrl_nv;

    assign ctrl    = desc_words[W_CTRL*DW +: DW];
    assign ext     = desc_words[W_EXT*DW  +: DW];
    assign src0    = desc_words[W_SRC*DW  +: DW];
    assign dst0    = desc_words[W_DST*DW  +: DW];
    assign link    = desc_words[W_LINK*DW +: DW];
    assign ctrl_nv = ctrl & ~(DW'(1) << C_VALID);

    always_comb begin
        n         = q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        cap_en    = 1'b0;
        done      = 1'b0;
        xfer      = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (dptr_we) n.dptr = dptr_wdata;
                if (bell && cfg_en) begin
                    n.st     = S_FETCH;
                    n.widx   = '0;
                    n.halted = 1'b0;
                    n.bell   = 1'b1;
                end
            end
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = {q.dptr[DW-1:ALIGN], q.widx, {(ALIGN-IW){1'b0}}};
                xfer     = mem_ready;
                if (xfer) begin
                    cap_en = 1'b1;
                    if (q.widx == IW'(WORDS-1)) n.st = S_CHECK;
                    else                        n.widx = q.widx + 1'b1;
                end
            end
            S_CHECK: begin
                if (!ctrl[C_VALID]) begin
                    n.valid  = 1'b0;
                    n.halted = 1'b1;
                    n.bell   = 1'b0;
                    n.st     = S_IDLE;
                end else begin
                    n.valid = 1'b1;
                    n.bytes = ext[BCW-1:0];
                    n.src   = {ext[DW-1 -: 4], src0[DW-5:0]};
                    n.dst   = {ext[DW-5 -: 4], dst0[DW-5:0]};
                    n.st    = (ext[BCW-1:0] == '0) ? S_FIN : S_RD;
                end
            end
            S_RD: begin
                mem_req  = 1'b1;
                mem_addr = {q.src[DW-1:2], 2'b00};
                xfer     = mem_ready;
                if (xfer) begin
                    n.data = mem_rdata;
                    n.st   = S_WR;
                end
            end
            S_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {q.dst[DW-1:2], 2'b00};
                mem_wdata = q.data;
                xfer      = mem_ready;
                if (xfer) begin
                    n.src   = q.src + DW'(STEP);
                    n.dst   = q.dst + DW'(STEP);
                    n.bytes = (q.bytes > BCW'(STEP)) ? q.bytes - BCW'(STEP) : '0;
                    if (!cfg_en) begin
                        n.halted = 1'b1;
                        n.bell   = 1'b0;
                        n.st     = S_IDLE;
                    end else if (q.bytes <= BCW'(STEP)) begin
                        n.st = S_FIN;
                    end else begin
                        n.st = S_RD;
                    end
                end
            end
            S_FIN: begin
                done = 1'b1;
                if (ctrl[1:0] != 2'd0)  n.st = S_STWB;
                else if (ctrl[C_CONS])  n.st = S_CLRV;
                else                    n.st = S_NEXT;
            end
            S_STWB: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = ctrl[C_SPSEL] ? {sptr[DW-1:2], 2'b00}
                         : {q.dptr[DW-1:ALIGN], IW'(W_DONE), {(ALIGN-IW){1'b0}}};
                case (ctrl[1:0])
                    2'd1:    mem_wdata = {{(DW-3){1'b0}}, q.bell, q.valid, q.halted};
                    2'd2:    mem_wdata = ctrl_nv;
                    default: mem_wdata = {{(DW-BCW){1'b0}}, q.bytes};
                endcase
                xfer = mem_ready;
                if (xfer) n.st = ctrl[C_CONS] ? S_CLRV : S_NEXT;
            end
            S_CLRV: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {q.dptr[DW-1:ALIGN], {ALIGN{1'b0}}};
                mem_wdata = ctrl_nv;
                xfer      = mem_ready;
                if (xfer) n.st = S_NEXT;
            end
            S_NEXT: begin
                n.dptr = {link[LINK_W-1:0], {ALIGN{1'b0}}};
                if (!cfg_en) begin
                    n.halted = 1'b1;
                    n.bell   = 1'b0;
                    n.st     = S_IDLE;
                end else begin
                    n.widx = '0;
                    n.st   = S_FETCH;
                end
            end
            default: n.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= S_IDLE;
            q.halted <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign cap_idx   = q.widx;
    assign done_ie   = ctrl[C_IE];
    assign dptr      = q.dptr;
    assign stat_bits = {q.bell, q.valid, q.halted};
    assign bytes     = q.bytes;

    p_halt_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        q.halted |-> !mem_req);
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));
    p_invalid_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_CHECK) && !ctrl[C_VALID] |=> q.halted && !q.valid);
    p_count_falls_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_WR) && xfer |=> q.bytes <= $past(q.bytes));
endmodule

// File: rtl/dbch_top.sv
module dbch_top
    import dbch_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ready,
    input  logic [31:0] mem_rdata,
    output logic        irq
);
    logic                cfg_en, bell, dptr_we, cap_en, done, done_ie;
    logic [DW-1:0]       sptr, dptr_wdata, dptr;
    logic [IW-1:0]       cap_idx;
    logic [WORDS*DW-1:0] desc_words;
    logic [2:0]          stat_bits;
    logic [BCW-1:0]      bytes;

    dbch_regs u_regs (
        .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
        .cfg_en, .sptr, .bell, .dptr_we, .dptr_wdata,
        .done, .done_ie, .dptr, .stat_bits, .bytes, .irq
    );

    dbch_engine u_eng (
        .clk, .rst_n, .cfg_en, .bell, .dptr_we, .dptr_wdata, .sptr,
        .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ready, .mem_rdata,
        .cap_en, .cap_idx, .desc_words, .done, .done_ie,
        .dptr, .stat_bits, .bytes
    );

    dbch_desc_store #(.DW(DW), .WORDS(WORDS)) u_store (
        .clk, .rst_n, .cap_en, .cap_idx, .cap_data(mem_rdata), .words(desc_words)
    );
endmodule

// File: tb/dbch_top_tb_top.sv
`timescale 1ns/1ps
module dbch_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        mem_req, mem_we, mem_ready, irq;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    logic [31:0] mem [0:255];
    logic        pk_en;
    logic [7:0]  pk_a;
    logic [31:0] pk_d;
    int          n_req_cyc, n_dst_wr;
    logic [3:0]  src_nib, dst_nib;
    int          rdy_mode, rdy_cnt;
    int          n_chk, n_fail;

    always #2.5 clk = ~clk;

    dbch_top dut_i (
        .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
        .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ready, .mem_rdata, .irq
    );

    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= '0;
            n_req_cyc <= 0; n_dst_wr <= 0; src_nib <= '0; dst_nib <= '0;
        end else begin
            if (pk_en) mem[pk_a] <= pk_d;
            else if (mem_req && mem_ready && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            if (mem_req) n_req_cyc <= n_req_cyc + 1;
            if (mem_req && mem_ready && mem_we && mem_addr[9:6] == 4'hC) n_dst_wr <= n_dst_wr + 1;
            if (mem_req && mem_ready && !mem_we && mem_addr[9:8] == 2'b10) src_nib <= mem_addr[31:28];
            if (mem_req && mem_ready && mem_we && mem_addr[9:8] == 2'b11) dst_nib <= mem_addr[31:28];
        end
    end

    always @(negedge clk) begin
        rdy_cnt <= rdy_cnt + 1;
        case (rdy_mode)
            0:       mem_ready <= 1'b1;
            1:       mem_ready <= rdy_cnt[0];
            default: mem_ready <= (rdy_cnt % 3 == 0);
        endcase
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] byte_addr, input logic [31:0] d);
        @(negedge clk);
        pk_en = 1'b1; pk_a = byte_addr[9:2]; pk_d = d;
        @(negedge clk);
        pk_en = 1'b0;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic put_desc(input logic [31:0] at, input logic [31:0] ctrl,
                            input logic [31:0] ext, input logic [31:0] src,
                            input logic [31:0] dst, input logic [31:0] next_at);
        poke(at,      ctrl);
        poke(at + 4,  ext);
        poke(at + 8,  src);
        poke(at + 16, dst);
        poke(at + 24, 32'h5555_5555);
        poke(at + 28, next_at >> 5);
    endtask

    task automatic wait_halt();
        logic [31:0] s;
        int t = 0;
        do begin
            @(negedge clk);
            rd_reg(3'd5, s);
            t++;
        end while (!s[0] && t < 5000);
        if (!s[0]) check("R6 chain never halted", s, 32'h1);
    endtask

    task automatic run_chain(input logic [31:0] at);
        logic [31:0] s;
        wr_reg(3'd1, at);
        wr_reg(3'd0, 32'h1);
        wr_reg(3'd3, 32'hFFFF_FFFF);
        rd_reg(3'd5, s);
        check("R2 running shows doorbell, not halted", s & 32'h5, 32'h4);
        wait_halt();
    endtask

    task automatic run_all();
        logic [31:0] v, ctrl, exp_t;
        int nw, n0, n1, base_wr;
        // R1 reset state
        rd_reg(3'd5, v); check("R1 status after reset", v, 32'h1);
        rd_reg(3'd4, v); check("R1 pending after reset", v, 32'h0);
        rd_reg(3'd6, v); check("R1 byte count after reset", v, 32'h0);
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        check("R1 mem_req after reset", {31'b0, mem_req}, 32'h0);

        // R2 doorbell ignored while disabled
        put_desc(32'h000, 32'h8000_0000, 32'd4, 32'h200, 32'h300, 32'h020);
        wr_reg(3'd1, 32'h0);
        wr_reg(3'd3, 32'h1);
        repeat (20) @(negedge clk);
        check("R2 disabled doorbell bus activity", n_req_cyc, 0);
        rd_reg(3'd5, v); check("R2 disabled doorbell status", v, 32'h1);

        // R5 / R11 / R9 byte count sweep
        for (int bc = 0; bc < 10; bc++) begin
            rdy_mode = bc % 3;
            put_desc(32'h000, 32'h8000_0000, bc, 32'h200, 32'h300, 32'h020);
            poke(32'h020, 32'h0);
            for (int i = 0; i < 4; i++) begin
                poke(32'h200 + 4*i, 32'hA000_0000 + bc*16 + i);
                poke(32'h300 + 4*i, 32'hDEAD_0000 + i);
            end
            run_chain(32'h000);
            nw = (bc + 3) / 4;
            for (int i = 0; i < 4; i++)
                check($sformatf("R5 bc=%0d dst word %0d", bc, i), mem[8'hC0 + i],
                      (i < nw) ? 32'hA000_0000 + bc*16 + i : 32'hDEAD_0000 + i);
            rd_reg(3'd6, v); check("R11 byte count after completion", v, 32'h0);
            rd_reg(3'd5, v); check("R4 status after invalid stop", v, 32'h1);
            rd_reg(3'd1, v); check("R6 pointer at stop descriptor", v, 32'h020);
            rd_reg(3'd4, v); check("R9 pending set without enable", v, 32'h1);
            check("R9 irq low without enable", {31'b0, irq}, 32'h0);
            check("R8 no consume keeps valid", mem[0], 32'h8000_0000);
            wr_reg(3'd4, 32'h1);
            rd_reg(3'd4, v); check("R9 pending write-one clear", v, 32'h0);
        end

        // R3 / R6 / R9 chain of three with misaligned start pointer
        rdy_mode = 1;
        put_desc(32'h040, 32'h8000_0000, 32'd4, 32'h210, 32'h310, 32'h060);
        put_desc(32'h060, 32'h8000_0000, 32'd4, 32'h214, 32'h314, 32'h080);
        put_desc(32'h080, 32'h8000_0100, 32'd4, 32'h218, 32'h318, 32'h0A0);
        poke(32'h0A0, 32'h0);
        for (int i = 0; i < 3; i++) poke(32'h210 + 4*i, 32'h1234_0000 + i);
        run_chain(32'h05F);
        for (int i = 0; i < 3; i++)
            check($sformatf("R3 chain link %0d copied", i), mem[8'hC4 + i], 32'h1234_0000 + i);
        rd_reg(3'd1, v); check("R6 pointer after chain", v, 32'h0A0);
        check("R9 irq high with enable", {31'b0, irq}, 32'h1);
        wr_reg(3'd4, 32'h1);
        check("R9 irq drops after clear", {31'b0, irq}, 32'h0);

        // R7 / R8 completion action sweep
        wr_reg(3'd2, 32'h3F0);
        for (int st = 0; st < 4; st++) begin
            for (int sp = 0; sp < 2; sp++) begin
                rdy_mode = st % 3;
                ctrl = 32'h8000_0000 | (sp << 4) | (((st + sp) % 2) << 2) | st;
                put_desc(32'h000, ctrl, 32'd8, 32'h200, 32'h300, 32'h020);
                poke(32'h3F0, 32'h6666_6666);
                run_chain(32'h000);
                case (st)
                    1:       exp_t = 32'h6;
                    2:       exp_t = ctrl & 32'h7FFF_FFFF;
                    3:       exp_t = 32'h0;
                    default: exp_t = 32'h0;
                endcase
                check($sformatf("R7 st=%0d sp=%0d descriptor word", st, sp), mem[6],
                      (st != 0 && sp == 0) ? exp_t : 32'h5555_5555);
                check($sformatf("R7 st=%0d sp=%0d pointer target", st, sp), mem[8'hFC],
                      (st != 0 && sp == 1) ? exp_t : 32'h6666_6666);
                check($sformatf("R8 consume=%0d control word", (st + sp) % 2), mem[0],
                      ((st + sp) % 2 == 1) ? (ctrl & 32'h7FFF_FFFF) : ctrl);
                wr_reg(3'd4, 32'h1);
            end
        end

        // R5 address extension nibbles
        rdy_mode = 0;
        put_desc(32'h000, 32'h8000_0000, 32'h5A00_0008, 32'h200, 32'h300, 32'h020);
        run_chain(32'h000);
        check("R5 source upper nibble", {28'b0, src_nib}, 32'h5);
        check("R5 destination upper nibble", {28'b0, dst_nib}, 32'hA);

        // R10 disable during a long copy
        for (int i = 0; i < 16; i++) begin
            poke(32'h200 + 4*i, 32'hBEEF_0000 + i);
            poke(32'h300 + 4*i, 32'hDEAD_0000 + i);
        end
        put_desc(32'h000, 32'h8000_0000, 32'd64, 32'h200, 32'h300, 32'h020);
        base_wr = n_dst_wr;
        wr_reg(3'd1, 32'h000);
        wr_reg(3'd0, 32'h1);
        wr_reg(3'd3, 32'h1);
        repeat (12) @(negedge clk);
        wr_reg(3'd0, 32'h0);
        n0 = n_dst_wr - base_wr;
        wait_halt();
        n1 = n_dst_wr - base_wr;
        check("R10 at most one word after disable", {31'b0, (n1 - n0) <= 1}, 32'h1);
        check("R10 copy stopped early", {31'b0, n1 < 16}, 32'h1);
        rd_reg(3'd5, v); check("R10 halted status keeps valid", v, 32'h3);
        rd_reg(3'd6, v); check("R10 remaining byte count", v, 64 - 4*n1);
        if (n1 > 0 && n1 < 16) begin
            check("R10 last copied word", mem[8'hC0 + n1 - 1], 32'hBEEF_0000 + n1 - 1);
            check("R10 first uncopied word", mem[8'hC0 + n1], 32'hDEAD_0000 + n1);
        end
    endtask

    initial begin
        n_chk = 0; n_fail = 0; rdy_mode = 0; rdy_cnt = 0;
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        pk_en = 1'b0; pk_a = '0; pk_d = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule